// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the digital divider chain of a frequency synthesizer. On the fast clock it runs a dual-modulus prescaler. The prescaler divides by P or by P+1. A swallow counter sets how many prescaler cycles in each output period use P+1, and a main counter sets how many prescaler cycles make up one period. The feedback ratio is therefore P×N + A. On the reference clock a separate counter divides by R. Each chain emits a single-cycle pulse at its terminal count: `fp` on the fast side and `fr` on the reference side. A phase comparator downstream compares these two pulses.

The divide settings arrive as already-latched values. The block takes them in only at the end of a period, so a period in progress is never cut short or stretched by a write. The prescaler pair is chosen by a select bit and a parameter that gives the smaller modulus as a power of two. A power-saving input holds both chains at their start state, and both restart together when it is released. The block flags forbidden settings and clamps them to the nearest legal behaviour.

Top module: `pulse_swallow_div`

## Requirements
- R1: After reset or hold is released, the first `fp` pulse comes after exactly P×N+A fast-clock cycles. Later pulses follow every P×N+A cycles, and each pulse is one cycle wide.
- R2: With `p_sel`=1, P = 2^PRE_LOG2 (16 by default). With `p_sel`=0, P = 2^(PRE_LOG2+1) (32 by default).
- R3: After release, the first `fr` pulse comes after exactly R reference cycles. Later pulses follow every R cycles, and each pulse is one cycle wide.
- R4: The swallow count covers its full legal span. A=0 gives a period of P×N, and A=N−1 gives P×N+N−1.
- R5: A new A, N or `p_sel` applied during a period does not change that period. It first applies to the period that starts after the next `fp`.
- R6: A new R applied during a reference period first applies after the next `fr`.
- R7: While `pwr_save`=1, `fp` and `fr` stay low. After release both chains start from their load state, so with P×N+A equal to R the first `fp` and `fr` fall in the same cycle.
- R8: `cfg_err` is 1, combinationally, whenever N<3, R<3 or A≥N. Otherwise it is 0.
- R9: Forbidden settings are clamped. N below 3 acts as 3, R below 3 acts as 3, and A acts as min(A, N_eff−1).
- R10: While `rst_n` is low, `fp` and `fr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Fast clock being divided |
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset, valid in both clock domains |
| pwr_save | input | 1 | 1 holds both chains at their start state |
| p_sel | input | 1 | Prescaler pair select (1: small pair, 0: large pair) |
| a_val | input | A_W | Swallow count A |
| n_val | input | N_W | Main count N |
| r_val | input | R_W | Reference count R |
| fp | output | 1 | One-cycle feedback comparison pulse (fast domain) |
| fr | output | 1 | One-cycle reference comparison pulse (reference domain) |
| cfg_err | output | 1 | Forbidden setting present on the inputs |

## Verification
The bench builds the block with its defaults: PRE_LOG2=4, giving the 16/17 and 32/33 pairs, and fields of 7, 11 and 14 bits. It drives both clock ports from one clock, so `fp` and `fr` timing can be compared cycle for cycle. Random main counts stay at or below 40 and reference counts at or below 1200. This keeps each period short enough that many reloads, under both prescaler pairs, fit in one run. Directed cases reach the top of the swallow range (A=127 with N=128), the smallest legal counts, each clamp path, and a setting change made exactly at a period boundary.

// File: rtl/pss_pkg.sv
// Package: shared types for the pulse-swallow divider.
// Assumes nothing beyond IEEE 1800-2017.
package pss_pkg;

    // Modulus used by the prescaler for one prescaler cycle
    typedef enum logic {
        MOD_BASE  = 1'b0,   // divide by P
        MOD_PLUS1 = 1'b1    // divide by P+1
    } mod_e;

    // Smallest legal value for the main and reference counters
    localparam int unsigned MIN_COUNT = 3;

endpackage

// File: rtl/pss_cfg_guard.sv
// Module: pss_cfg_guard
// Checks the raw divide settings for forbidden values and produces the
// clamped settings that the counters actually use.
// Assumes A_W <= N_W so that A can be compared with N after zero extension.
module pss_cfg_guard #(
    parameter int A_W = 7,
    parameter int N_W = 11,
    parameter int R_W = 14
) (
    input  logic [A_W-1:0] a_raw,
    input  logic [N_W-1:0] n_raw,
    input  logic [R_W-1:0] r_raw,
    output logic [A_W-1:0] a_eff,
    output logic [N_W-1:0] n_eff,
    output logic [R_W-1:0] r_eff,
    output logic           err
);
    localparam logic [N_W-1:0] N_MIN = N_W'(pss_pkg::MIN_COUNT);
    localparam logic [R_W-1:0] R_MIN = R_W'(pss_pkg::MIN_COUNT);

    logic           n_low;
    logic           r_low;
    logic           a_big;
    logic [N_W-1:0] a_wide;

    // Flag forbidden settings and clamp each one to its nearest legal value
    always_comb begin
        a_wide = N_W'(a_raw);
        n_low  = (n_raw < N_MIN);
        r_low  = (r_raw < R_MIN);
        a_big  = (a_wide >= n_raw);
        n_eff  = n_low ? N_MIN : n_raw;
        r_eff  = r_low ? R_MIN : r_raw;
        a_eff  = (a_wide >= n_eff) ? A_W'(n_eff - N_W'(1)) : a_raw;
        err    = n_low | r_low | a_big;
    end

endmodule

// File: rtl/pss_prescaler.sv
// Module: pss_prescaler
// Dual-modulus prescaler. It counts fast-clock cycles down to zero, then
// reloads with the modulus chosen for the next prescaler cycle. tick marks
// the last cycle of each prescaler cycle.
// Assumes rst_n and hold are synchronous to clk, and that nxt_mod/sel_small
// are valid whenever a reload happens (hold, reset or tick).
module pss_prescaler #(
    parameter int PRE_LOG2 = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hold,
    input  logic           sel_small,
    input  pss_pkg::mod_e  nxt_mod,
    output logic           tick
);
    localparam int PC_W = PRE_LOG2 + 2;
    localparam logic [PC_W-1:0] TOP_SMALL    = PC_W'((1 << PRE_LOG2) - 1);
    localparam logic [PC_W-1:0] TOP_SMALL_P1 = PC_W'(1 << PRE_LOG2);
    localparam logic [PC_W-1:0] TOP_LARGE    = PC_W'((2 << PRE_LOG2) - 1);
    localparam logic [PC_W-1:0] TOP_LARGE_P1 = PC_W'(2 << PRE_LOG2);

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] load_val;

    // Reload value for the coming prescaler cycle, and terminal detect
    always_comb begin
        load_val = (sel_small ? TOP_SMALL : TOP_LARGE)
                 + ((nxt_mod == pss_pkg::MOD_PLUS1) ? PC_W'(1) : PC_W'(0));
        tick     = (pc_q == '0);
    end

    // Count down; reload on reset, hold or terminal count
    always_ff @(posedge clk) begin
        if (!rst_n || hold || tick) begin
            pc_q <= load_val;
        end else begin
            pc_q <= pc_q - PC_W'(1);
        end
    end

    // R2
    prescale_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !hold) |=> (pc_q == TOP_SMALL || pc_q == TOP_SMALL_P1 ||
                             pc_q == TOP_LARGE || pc_q == TOP_LARGE_P1));

endmodule

// File: rtl/pss_swallow_ctl.sv
// Module: pss_swallow_ctl
// Swallow counter and main counter, stepped once per prescaler cycle.
// It steers the prescaler modulus (P+1 while swallow counts remain) and
// marks the end of each output period with a one-cycle fp pulse. New
// settings are taken only at a period boundary, on reset, or on hold.
// Assumes a_eff < n_eff and n_eff >= 3 (guaranteed by pss_cfg_guard).
module pss_swallow_ctl #(
    parameter int A_W = 7,
    parameter int N_W = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hold,
    input  logic           tick,
    input  logic [A_W-1:0] a_eff,
    input  logic [N_W-1:0] n_eff,
    input  logic           sel_in,
    output pss_pkg::mod_e  nxt_mod,
    output logic           nxt_sel,
    output logic           fp
);
    logic [N_W-1:0] nc_q, nc_n;
    logic [A_W-1:0] sw_q, sw_n;
    logic           sel_q;
    logic           restart;
    logic           boundary;

    // Next counter state: reload at a boundary or restart, step on tick
    always_comb begin
        restart  = hold || !rst_n;
        boundary = tick && (nc_q == N_W'(1));
        nc_n     = nc_q;
        sw_n     = sw_q;
        nxt_sel  = sel_q;
        if (restart || boundary) begin
            nc_n    = n_eff;
            sw_n    = a_eff;
            nxt_sel = sel_in;
        end else if (tick) begin
            nc_n = nc_q - N_W'(1);
            sw_n = (sw_q != '0) ? (sw_q - A_W'(1)) : '0;
        end
        nxt_mod = (sw_n != '0) ? pss_pkg::MOD_PLUS1 : pss_pkg::MOD_BASE;
    end

    // Register counters, the period's prescaler pair and the fp pulse
    always_ff @(posedge clk) begin
        nc_q  <= nc_n;
        sw_q  <= sw_n;
        sel_q <= nxt_sel;
        fp    <= restart ? 1'b0 : boundary;
    end

    // R1
    fp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fp |=> !fp);

    // R9
    swallow_lt_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |-> (N_W'(sw_q) < nc_q));

    // R7
    fp_quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !fp);

endmodule

// File: rtl/pss_ref_div.sv
// Module: pss_ref_div
// Programmable reference divider. It counts reference cycles down and
// emits a one-cycle fr pulse on each terminal count, then reloads with the
// current setting. A new setting therefore applies only after the next pulse.
// Assumes r_eff >= 3 and that rst_n/hold are synchronous to clk.
module pss_ref_div #(
    parameter int R_W = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hold,
    input  logic [R_W-1:0] r_eff,
    output logic           fr
);
    logic [R_W-1:0] rc_q;

    // Count down and pulse fr at terminal count; restart on reset or hold
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            rc_q <= r_eff - R_W'(1);
            fr   <= 1'b0;
        end else if (rc_q == '0) begin
            rc_q <= r_eff - R_W'(1);
            fr   <= 1'b1;
        end else begin
            rc_q <= rc_q - R_W'(1);
            fr   <= 1'b0;
        end
    end

    // R3
    fr_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fr |=> !fr);

    // R7
    fr_quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !fr);

endmodule

// File: rtl/pulse_swallow_div.sv
// Module: pulse_swallow_div
// Top of the pulse-swallow divider. It joins the setting guard, the
// prescaler with its swallow/main control on the fast clock, and the
// reference divider on the reference clock.
// Assumes rst_n and pwr_save are synchronous to both clocks (supplied by the
// surrounding clock/reset logic) and that a_val/n_val/r_val/p_sel are latched.
module pulse_swallow_div #(
    parameter int PRE_LOG2 = 4,
    parameter int A_W      = 7,
    parameter int N_W      = 11,
    parameter int R_W      = 14
) (
    input  logic           vco_clk,
    input  logic           ref_clk,
    input  logic           rst_n,
    input  logic           pwr_save,
    input  logic           p_sel,
    input  logic [A_W-1:0] a_val,
    input  logic [N_W-1:0] n_val,
    input  logic [R_W-1:0] r_val,
    output logic           fp,
    output logic           fr,
    output logic           cfg_err
);
    logic [A_W-1:0] a_eff;
    logic [N_W-1:0] n_eff;
    logic [R_W-1:0] r_eff;
    logic           tick;
    logic           nxt_sel;
    pss_pkg::mod_e  nxt_mod;

    pss_cfg_guard #(.A_W(A_W), .N_W(N_W), .R_W(R_W)) u_guard (
        .a_raw (a_val),
        .n_raw (n_val),
        .r_raw (r_val),
        .a_eff (a_eff),
        .n_eff (n_eff),
        .r_eff (r_eff),
        .err   (cfg_err)
    );

    pss_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
        .clk       (vco_clk),
        .rst_n     (rst_n),
        .hold      (pwr_save),
        .sel_small (nxt_sel),
        .nxt_mod   (nxt_mod),
        .tick      (tick)
    );

    pss_swallow_ctl #(.A_W(A_W), .N_W(N_W)) u_ctl (
        .clk     (vco_clk),
        .rst_n   (rst_n),
        .hold    (pwr_save),
        .tick    (tick),
        .a_eff   (a_eff),
        .n_eff   (n_eff),
        .sel_in  (p_sel),
        .nxt_mod (nxt_mod),
        .nxt_sel (nxt_sel),
        .fp      (fp)
    );

    pss_ref_div #(.R_W(R_W)) u_ref (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .hold  (pwr_save),
        .r_eff (r_eff),
        .fr    (fr)
    );

endmodule

// File: tb/tb_pulse_swallow_div.sv
module tb_pulse_swallow_div;
    localparam int PRE_LOG2 = 4;
    localparam int A_W      = 7;
    localparam int N_W      = 11;
    localparam int R_W      = 14;
    localparam int WATCHDOG = 190000;

    logic           clk      = 1'b0;
    logic           rst_n    = 1'b0;
    logic           pwr_save = 1'b0;
    logic           p_sel    = 1'b1;
    logic [A_W-1:0] a_val    = '0;
    logic [N_W-1:0] n_val    = N_W'(10);
    logic [R_W-1:0] r_val    = R_W'(10);
    logic           fp, fr, cfg_err;

    int checks   = 0;
    int failures = 0;
    int cyc      = 0;

    always #4 clk = ~clk;   // 125 MHz

    pulse_swallow_div #(.PRE_LOG2(PRE_LOG2), .A_W(A_W), .N_W(N_W), .R_W(R_W)) dut (
        .vco_clk (clk),
        .ref_clk (clk),
        .rst_n   (rst_n),
        .pwr_save(pwr_save),
        .p_sel   (p_sel),
        .a_val   (a_val),
        .n_val   (n_val),
        .r_val   (r_val),
        .fp      (fp),
        .fr      (fr),
        .cfg_err (cfg_err)
    );

    function automatic int eff_n(int n);
        return (n < 3) ? 3 : n;
    endfunction

    function automatic int fp_period(bit sel, int a, int n);
        int ne = eff_n(n);
        int ae = (a > ne - 1) ? ne - 1 : a;
        int p  = sel ? (1 << PRE_LOG2) : (2 << PRE_LOG2);
        return p * ne + ae;
    endfunction

    function automatic int fr_period(int r);
        return (r < 3) ? 3 : r;
    endfunction

    function automatic bit want_err(int a, int n, int r);
        return (n < 3) || (r < 3) || (a >= n);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Watchdog: an expired run counts as a failure and still reports
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc == WATCHDOG) begin
                failures++;
                $display("FAIL R1 watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
                $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    // Hold, load a setting, release, then time the first two fp and fr pulses
    task automatic run_case(input bit sel, input int a, input int n, input int r,
                            input string tag);
        int efp, efr, limit;
        int k = 0, nfp = 0, nfr = 0;
        int fp_t[2] = '{-1, -1};
        int fr_t[2] = '{-1, -1};
        bit quiet = 1'b1;
        @(negedge clk);
        pwr_save = 1'b1;
        p_sel = sel;
        a_val = A_W'(a);
        n_val = N_W'(n);
        r_val = R_W'(r);
        #1;
        check(cfg_err == want_err(a, n, r), "R8", "cfg_err", int'(cfg_err),
              int'(want_err(a, n, r)));
        repeat (4) begin
            @(negedge clk);
            if (fp || fr) quiet = 1'b0;
        end
        check(quiet, "R7", "pulses during hold", int'(!quiet), 0);
        efp   = fp_period(sel, a, n);
        efr   = fr_period(r);
        limit = 2 * ((efp > efr) ? efp : efr) + 8;
        pwr_save = 1'b0;
        while ((nfp < 2 || nfr < 2) && k < limit) begin
            @(negedge clk);
            k++;
            if (fp && nfp < 2) begin fp_t[nfp] = k; nfp++; end
            if (fr && nfr < 2) begin fr_t[nfr] = k; nfr++; end
        end
        check(fp_t[0] == efp, {tag, "/R1"}, "first fp cycle", fp_t[0], efp);
        check(fp_t[1] - fp_t[0] == efp, {tag, "/R1"}, "fp interval",
              fp_t[1] - fp_t[0], efp);
        check(fr_t[0] == efr, {tag, "/R3"}, "first fr cycle", fr_t[0], efr);
        check(fr_t[1] - fr_t[0] == efr, {tag, "/R3"}, "fr interval",
              fr_t[1] - fr_t[0], efr);
    endtask

    // Change every setting exactly at a shared boundary: the running period keeps the old values
    task automatic run_switch();
        int k = 0, nfp = 0, nfr = 0;
        int fp_t[3] = '{-1, -1, -1};
        int fr_t[3] = '{-1, -1, -1};
        bit switched = 1'b0;
        @(negedge clk);
        pwr_save = 1'b1;
        p_sel = 1'b1; a_val = A_W'(3); n_val = N_W'(10); r_val = R_W'(163);
        repeat (3) @(negedge clk);
        pwr_save = 1'b0;
        while ((nfp < 3 || nfr < 3) && k < 700) begin
            @(negedge clk);
            k++;
            if (fp && nfp < 3) begin fp_t[nfp] = k; nfp++; end
            if (fr && nfr < 3) begin fr_t[nfr] = k; nfr++; end
            if (nfp == 1 && !switched) begin
                switched = 1'b1;
                p_sel = 1'b0; a_val = A_W'(5); n_val = N_W'(7); r_val = R_W'(300);
            end
        end
        check(fp_t[0] == 163 && fr_t[0] == 163, "R7", "aligned first pulses fp",
              fp_t[0], 163);
        check(fr_t[0] == 163, "R7", "aligned first pulses fr", fr_t[0], 163);
        check(fp_t[1] - fp_t[0] == 163, "R5", "period after mid-run write",
              fp_t[1] - fp_t[0], 163);
        check(fp_t[2] - fp_t[1] == 229, "R5", "period with new A/N/p_sel",
              fp_t[2] - fp_t[1], 229);
        check(fr_t[1] - fr_t[0] == 163, "R6", "ref period after write",
              fr_t[1] - fr_t[0], 163);
        check(fr_t[2] - fr_t[1] == 300, "R6", "ref period with new R",
              fr_t[2] - fr_t[1], 300);
    endtask

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'd4242);
        // R10: outputs low while reset is held
        repeat (3) begin
            @(negedge clk);
            check(!fp && !fr, "R10", "outputs in reset", int'(fp | fr), 0);
        end
        rst_n = 1'b1;

        // Directed corners
        run_case(1'b1, 0,   3,   3,  "R4");   // smallest legal counts, A=0
        run_case(1'b0, 0,   5,   7,  "R2");   // large pair
        run_case(1'b1, 2,   5,   7,  "R2");   // small pair
        run_case(1'b1, 9,   10,  50, "R4");   // A = N-1
        run_case(1'b1, 127, 128, 900, "R4");  // top of swallow range
        run_case(1'b1, 1,   2,   5,  "R9");   // N below minimum
        run_case(1'b0, 0,   0,   0,  "R9");   // N and R zero
        run_case(1'b0, 12,  12,  40, "R9");   // A equal to N
        run_case(1'b1, 20,  5,   2,  "R9");   // A above N, R below minimum
        run_switch();

        // Constrained random settings
        for (int i = 0; i < 20; i++) begin
            int n, a, r;
            bit s;
            n = int'($urandom_range(40, 3));
            a = int'($urandom_range(n - 1, 0));
            r = int'($urandom_range(1200, 3));
            s = 1'($urandom_range(1, 0));
            run_case(s, a, n, r, "R1");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule